// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast oscillator-side clock by a programmable integer N = P·M + A. A short prescaler runs at full input rate and counts either P or P+1 input cycles per output tick. A program counter (M) and a swallow counter (A) advance only once per prescaler tick. They are clocked by the input clock but enabled by the tick, so almost all of the programmable logic toggles at the prescaled rate. The prescaler counts P+1 while the swallow counter is nonzero and P for the rest of the M prescaler cycles. Any integer ratio in the legal range can be reached in steps of one.

The divided output is a single-cycle pulse, one per period, for a phase detector. The M and A inputs are sampled only at the period boundary, when both counters reload. A setting with M equal to zero, or with A greater than M, is rejected. In that case the status output is raised and the last accepted setting stays in force. After reset the divider runs with the parameter values M_RST and A_RST until the first boundary.

Top module: `pulse_swallow_div`

## Requirements
- R1: While reset is low, fb_clk_o and cfg_bad_o are 0. The first fb_clk_o pulse after reset release comes P·M_RST + A_RST input cycles later. M_RST and A_RST are used for that first period, whatever the inputs are.
- R2: With an accepted setting (1 ≤ M, A ≤ M), the distance between consecutive fb_clk_o pulses is exactly P·M + A input cycles. This includes the edge settings A = 0 and A = M.
- R3: fb_clk_o is high for exactly one input cycle in each period.
- R4: A change of prog_cnt_i or swallow_cnt_i in the middle of a period does not alter that period. The new value governs the next period. It is sampled in the last cycle of a period, which is the cycle just before the pulse.
- R5: If swallow_cnt_i > prog_cnt_i when sampled, cfg_bad_o goes to 1 together with the pulse that closes that period. The following period keeps the last accepted ratio.
- R6: If prog_cnt_i = 0 when sampled, cfg_bad_o goes to 1 and the last accepted ratio is kept.
- R7: When an accepted setting is sampled, cfg_bad_o returns to 0 together with the pulse that closes that period. cfg_bad_o changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_cnt_i | input | M_W | Program count M |
| swallow_cnt_i | input | A_W | Swallow count A |
| fb_clk_o | output | 1 | One-cycle pulse, once per divided period |
| cfg_bad_o | output | 1 | 1 when the last sampled setting was rejected |

## Verification
The bench sweeps every legal pair (M, A) for a small prescaler and width set, and measures the pulse spacing against P·M + A. The A = 0 and A = M corners show whether the P and P+1 moduli are swapped or applied for one cycle too many. A sweep over illegal pairs with A > M, plus the M = 0 case, shows whether the last accepted ratio is kept and the flag raised. Changes made in the middle of a period, and inputs that are illegal during reset, separate sampling at the boundary from sampling at any time.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } mod_sel_e;

    // A setting is usable when the program count is nonzero and the
    // swallow count does not exceed it.
    function automatic logic cfg_ok(input int unsigned m, input int unsigned a);
        return (m != 0) && (a <= m);
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import pswal_pkg::*;
#(
    parameter int P = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  mod_sel_e mode,
    output logic     tick
);
    localparam int PW = $clog2(P + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [PW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = (mode == MOD_HIGH) ? PW'(P) : PW'(P - 1);
        tick = (st_q.cnt == lim);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold
    import pswal_pkg::*;
#(
    parameter int M_W   = 5,
    parameter int A_W   = 3,
    parameter int M_RST = 3,
    parameter int A_RST = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reload,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    output logic [M_W-1:0] ld_m,
    output logic [A_W-1:0] ld_a,
    output logic [M_W-1:0] act_m,
    output logic [A_W-1:0] act_a,
    output logic           bad_o
);
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           bad;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    ok;

    always_comb begin
        st_d = st_q;
        ok   = cfg_ok(int'(m_in), int'(a_in));
        ld_m = ok ? m_in : st_q.m;
        ld_a = ok ? a_in : st_q.a;
        if (reload) begin
            st_d.m   = ld_m;
            st_d.a   = ld_a;
            st_d.bad = !ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.m   <= M_W'(M_RST);
            st_q.a   <= A_W'(A_RST);
            st_q.bad <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_m = st_q.m;
    assign act_a = st_q.a;
    assign bad_o = st_q.bad;

endmodule

// File: rtl/psd_counters.sv
module psd_counters
    import pswal_pkg::*;
#(
    parameter int M_W   = 5,
    parameter int A_W   = 3,
    parameter int M_RST = 3,
    parameter int A_RST = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [M_W-1:0] ld_m,
    input  logic [A_W-1:0] ld_a,
    output mod_sel_e       mode,
    output logic           terminal,
    output logic [M_W-1:0] m_cnt,
    output logic [A_W-1:0] a_cnt,
    output logic           pulse_o
);
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        mode       = (st_q.a != '0) ? MOD_HIGH : MOD_LOW;
        terminal   = tick && (st_q.m == M_W'(1));
        st_d.pulse = terminal;
        if (terminal) begin
            st_d.m = ld_m;
            st_d.a = ld_a;
        end else if (tick) begin
            st_d.m = st_q.m - 1'b1;
            if (st_q.a != '0) begin
                st_d.a = st_q.a - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.m     <= M_W'(M_RST);
            st_q.a     <= A_W'(A_RST);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_cnt   = st_q.m;
    assign a_cnt   = st_q.a;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import pswal_pkg::*;
#(
    parameter int P     = 4,
    parameter int M_W   = 5,
    parameter int A_W   = 3,
    parameter int M_RST = 3,
    parameter int A_RST = 1
) (
    input  logic           clk_vco,
    input  logic           rst_n,
    input  logic [M_W-1:0] prog_cnt_i,
    input  logic [A_W-1:0] swallow_cnt_i,
    output logic           fb_clk_o,
    output logic           cfg_bad_o
);
    mod_sel_e       mod_hi;
    logic           pre_tick;
    logic           reload;
    logic [M_W-1:0] ld_m, act_m, m_cnt;
    logic [A_W-1:0] ld_a, act_a, a_cnt;

    psd_prescaler #(.P(P)) u_pre (
        .clk  (clk_vco),
        .rst_n(rst_n),
        .mode (mod_hi),
        .tick (pre_tick)
    );

    psd_cfg_hold #(.M_W(M_W), .A_W(A_W), .M_RST(M_RST), .A_RST(A_RST)) u_cfg (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .reload(reload),
        .m_in  (prog_cnt_i),
        .a_in  (swallow_cnt_i),
        .ld_m  (ld_m),
        .ld_a  (ld_a),
        .act_m (act_m),
        .act_a (act_a),
        .bad_o (cfg_bad_o)
    );

    psd_counters #(.M_W(M_W), .A_W(A_W), .M_RST(M_RST), .A_RST(A_RST)) u_cnt (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .tick    (pre_tick),
        .ld_m    (ld_m),
        .ld_a    (ld_a),
        .mode    (mod_hi),
        .terminal(reload),
        .m_cnt   (m_cnt),
        .a_cnt   (a_cnt),
        .pulse_o (fb_clk_o)
    );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int M_W = 5,
    parameter int A_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fb,
    input logic           bad,
    input logic           tick,
    input logic           mode_hi,
    input logic [M_W-1:0] m_cnt,
    input logic [A_W-1:0] a_cnt,
    input logic [M_W-1:0] act_m,
    input logic [A_W-1:0] act_a
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fb |=> !fb); // R3

    AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(a_cnt) <= int'(m_cnt)); // R2

    AST_MODE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_hi) |-> $past(tick)); // R2

    AST_FLAG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bad) |-> fb); // R7

    AST_HELD_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m != '0) && (int'(act_a) <= int'(act_m))); // R5

    AST_HELD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_m) || !$stable(act_a)) |-> fb); // R4

endmodule

bind pulse_swallow_div psd_checker #(.M_W(M_W), .A_W(A_W)) u_chk (
    .clk    (clk_vco),
    .rst_n  (rst_n),
    .fb     (fb_clk_o),
    .bad    (cfg_bad_o),
    .tick   (pre_tick),
    .mode_hi(mod_hi == pswal_pkg::MOD_HIGH),
    .m_cnt  (m_cnt),
    .a_cnt  (a_cnt),
    .act_m  (act_m),
    .act_a  (act_a)
);

// File: tb/sim_pulse_swallow_div.sv
`timescale 1ns/1ps
module sim_pulse_swallow_div;
    localparam int P     = 4;
    localparam int M_W   = 5;
    localparam int A_W   = 3;
    localparam int M_RST = 3;
    localparam int A_RST = 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [M_W-1:0] m_in = '0;
    logic [A_W-1:0] a_in = '0;
    logic           fb, bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pulse_swallow_div #(.P(P), .M_W(M_W), .A_W(A_W), .M_RST(M_RST), .A_RST(A_RST)) u0 (
        .clk_vco      (clk),
        .rst_n        (rst_n),
        .prog_cnt_i   (m_in),
        .swallow_cnt_i(a_in),
        .fb_clk_o     (fb),
        .cfg_bad_o    (bad)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges from now until fb is seen high; also report whether
    // fb was high on the first negedge (pulse wider than one cycle).
    task automatic measure(output int cnt, output bit wide);
        cnt  = 0;
        wide = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1 && fb) wide = 1;
        end while (!fb && cnt < 1000);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int  n;
        bit  w;
        int  last_n;
        // R1: illegal inputs during reset must not affect the first period
        m_in = M_W'(1);
        a_in = A_W'(4);
        repeat (4) @(negedge clk);
        chk("R1 fb in reset", int'(fb), 0);
        chk("R1 bad in reset", int'(bad), 0);
        rst_n = 1'b1;
        measure(n, w);
        chk("R1 first period", n, P * M_RST + A_RST);
        chk("R6/R5 flag after illegal reset input", int'(bad), 1);
        measure(n, w);
        chk("R5 retained reset ratio", n, P * M_RST + A_RST);
        chk("R3 pulse width", int'(w), 0);

        // R2 exhaustive legal sweep
        last_n = P * M_RST + A_RST;
        for (int m = 1; m < (1 << M_W); m++) begin
            for (int a = 0; a < (1 << A_W); a++) begin
                if (a <= m) begin
                    m_in = M_W'(m);
                    a_in = A_W'(a);
                    measure(n, w);
                    chk("R4 old period kept", n, last_n);
                    chk("R7 flag clear", int'(bad), 0);
                    measure(n, w);
                    chk("R2 period", n, P * m + a);
                    chk("R3 pulse width", int'(w), 0);
                    last_n = P * m + a;
                end
            end
        end

        // R5 sweep: A > M keeps the last accepted ratio
        m_in = M_W'(6);
        a_in = A_W'(2);
        measure(n, w);
        measure(n, w);
        chk("R2 base 6/2", n, 26);
        for (int m = 1; m < 7; m++) begin
            for (int a = m + 1; a < (1 << A_W); a++) begin
                m_in = M_W'(m);
                a_in = A_W'(a);
                measure(n, w);
                chk("R5 flag set", int'(bad), 1);
                measure(n, w);
                chk("R5 ratio retained", n, 26);
            end
        end

        // R7 recover, then R6 with M = 0
        m_in = M_W'(5);
        a_in = A_W'(3);
        measure(n, w);
        chk("R7 flag cleared", int'(bad), 0);
        measure(n, w);
        chk("R7 new ratio", n, 23);
        m_in = '0;
        a_in = '0;
        measure(n, w);
        chk("R6 flag set", int'(bad), 1);
        measure(n, w);
        chk("R6 ratio retained", n, 23);

        // R4: change in the middle of a period
        m_in = M_W'(10);
        a_in = A_W'(7);
        measure(n, w);
        chk("R7 flag cleared", int'(bad), 0);
        repeat (5) @(negedge clk);
        m_in = M_W'(2);
        a_in = A_W'(1);
        measure(n, w);
        chk("R4 mid-period change ignored", n + 5, 47);
        measure(n, w);
        chk("R4 change applied next period", n, 9);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 fb in reset", int'(fb), 0);
        chk("R1 bad in reset", int'(bad), 0);
        rst_n = 1'b1;
        measure(n, w);
        chk("R1 first period after reset", n, P * M_RST + A_RST);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule